// File: doc/BRIEF.md
# Decode Interlock and Dispatch for Parallel Adder Units

This block is the issue logic at the decode stage of an in-order, four-stage pipeline (fetch, decode, execute, write-back). The execute stage has several identical adder units. None of them is pipelined. The block receives the two source register numbers and the destination register number of the instruction sitting in decode, together with a valid flag.

Each cycle it decides whether that instruction may leave decode. If it may, the block names the unit that takes it. It also keeps one pending bit per architectural register. The register file writes in the first half of a cycle and reads in the second half, so a result that finishes writing in a cycle can be consumed by the instruction in decode during that same cycle. No other forwarding path exists.

Each unit runs a small sequencer with three states: `U_IDLE`, `U_EXEC` and `U_WRBK`.
- `U_IDLE` moves to `U_EXEC` on dispatch.
- `U_EXEC` moves to `U_WRBK` after `EXEC_CYCLES` cycles.
- `U_WRBK` returns to `U_IDLE` after `WB_CYCLES` cycles.

The destination's pending bit clears at the end of the last write-back cycle. Each unit finishes independently of the others.

Top module: `issue_interlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every pending bit is 0. With the valid flag low, the stall is 0 and no unit is selected.
- R2: A valid instruction stalls while either of its source registers has a pending writer that is not in its final write-back cycle.
- R3: A writer in its final write-back cycle does not block a reader or a writer of the same register. With the defaults, an instruction that depends on the instruction dispatched just before it is dispatched 5 cycles after it.
- R4: A valid instruction stalls while its destination register has a pending writer that is not in its final write-back cycle.
- R5: A valid instruction stalls while no unit is idle. A unit stays occupied for `EXEC_CYCLES + WB_CYCLES` cycles after dispatch (5 with the defaults) and accepts again in the cycle after that.
- R6: A dispatch selects exactly one unit, the lowest-numbered idle one. Bit i of `disp_sel` is unit i.
- R7: The destination's pending bit is 1 from the edge of dispatch until the edge that ends the writer's final write-back cycle. With the defaults it is high for 5 cycles.
- R8: A stalled or invalid instruction selects no unit and changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_src_a | input | RW | First source register number |
| dec_src_b | input | RW | Second source register number |
| dec_dst | input | RW | Destination register number |
| dec_stall | output | 1 | Hold the fetch and decode registers this cycle |
| disp_sel | output | NUM_UNITS | One-hot unit receiving the instruction at this edge |
| reg_busy | output | NUM_REGS | Per-register pending-writer bits |

## Verification
A unit sequencer whose occupancy count is off by one shows up directly at the ports. The pending bit in `reg_busy` falls one cycle early or late, and a dependent instruction's stall releases on the wrong cycle, within five cycles of the dispatch. A lost or stuck pending bit makes `dec_stall` either miss a hazard or never release. A wrong unit choice is visible on `disp_sel` at the very edge where it happens. The sweeps compare these outputs every cycle against a countdown model of each unit. This exposes such faults by the first conflicting instruction.

// File: rtl/isu_pkg.sv
package isu_pkg;
    typedef enum logic [1:0] {
        U_IDLE = 2'd0,
        U_EXEC = 2'd1,
        U_WRBK = 2'd2
    } unit_state_e;
endpackage

// File: rtl/isu_exec_slot.sv
module isu_exec_slot
    import isu_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int EXEC_CYCLES = 3,
    parameter int WB_CYCLES   = 2,
    localparam int RW   = $clog2(NUM_REGS),
    localparam int MAXC = (EXEC_CYCLES > WB_CYCLES) ? EXEC_CYCLES : WB_CYCLES,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [RW-1:0]       dst_in,
    output logic                occupied,
    output logic [NUM_REGS-1:0] clr_onehot
);
    unit_state_e   state_q, state_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic [RW-1:0] dst_q;
    logic          last_wb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
            cnt_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            if (start) dst_q <= dst_in;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            U_IDLE: begin
                cnt_nx = '0;
                if (start) state_nx = U_EXEC;
            end
            U_EXEC: begin
                if (cnt_q == CW'(EXEC_CYCLES - 1)) begin
                    state_nx = U_WRBK;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            U_WRBK: begin
                if (cnt_q == CW'(WB_CYCLES - 1)) begin
                    state_nx = U_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            default: begin
                state_nx = U_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        occupied   = (state_q != U_IDLE);
        last_wb    = (state_q == U_WRBK) && (cnt_q == CW'(WB_CYCLES - 1));
        clr_onehot = '0;
        if (last_wb) clr_onehot[dst_q] = 1'b1;
    end
endmodule

// File: rtl/isu_unit_pick.sv
module isu_unit_pick #(
    parameter int NUM_UNITS = 3
) (
    input  logic [NUM_UNITS-1:0] free,
    output logic [NUM_UNITS-1:0] grant
);
    logic taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (free[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/isu_scoreboard.sv
module isu_scoreboard #(
    parameter int NUM_REGS = 16,
    localparam int RW = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [RW-1:0]       set_idx,
    input  logic [NUM_REGS-1:0] clr_vec,
    output logic [NUM_REGS-1:0] busy_q,
    output logic [NUM_REGS-1:0] busy_eff
);
    logic [NUM_REGS-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
        busy_eff = busy_q & ~clr_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock #(
    parameter int NUM_REGS    = 16,
    parameter int NUM_UNITS   = 3,
    parameter int EXEC_CYCLES = 3,
    parameter int WB_CYCLES   = 2,
    localparam int RW = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    input  logic [RW-1:0]        dec_src_a,
    input  logic [RW-1:0]        dec_src_b,
    input  logic [RW-1:0]        dec_dst,
    output logic                 dec_stall,
    output logic [NUM_UNITS-1:0] disp_sel,
    output logic [NUM_REGS-1:0]  reg_busy
);
    logic [NUM_UNITS-1:0]               unit_busy;
    logic [NUM_UNITS-1:0]               grant;
    logic [NUM_UNITS-1:0][NUM_REGS-1:0] clr_per;
    logic [NUM_REGS-1:0]                clr_vec;
    logic [NUM_REGS-1:0]                busy_eff;
    logic                               hazard;
    logic                               fire;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        isu_exec_slot #(
            .NUM_REGS   (NUM_REGS),
            .EXEC_CYCLES(EXEC_CYCLES),
            .WB_CYCLES  (WB_CYCLES)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (disp_sel[u]),
            .dst_in    (dec_dst),
            .occupied  (unit_busy[u]),
            .clr_onehot(clr_per[u])
        );
    end

    always_comb begin
        clr_vec = '0;
        for (int u = 0; u < NUM_UNITS; u++) clr_vec = clr_vec | clr_per[u];
    end

    isu_unit_pick #(.NUM_UNITS(NUM_UNITS)) u_pick (
        .free (~unit_busy),
        .grant(grant)
    );

    isu_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (fire),
        .set_idx (dec_dst),
        .clr_vec (clr_vec),
        .busy_q  (reg_busy),
        .busy_eff(busy_eff)
    );

    always_comb begin
        hazard    = busy_eff[dec_src_a] | busy_eff[dec_src_b] | busy_eff[dec_dst];
        dec_stall = dec_valid && (hazard || (&unit_busy));
        fire      = dec_valid && !dec_stall;
        disp_sel  = fire ? grant : '0;
    end
endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
    parameter int NUM_REGS  = 16,
    parameter int NUM_UNITS = 3,
    localparam int RW = $clog2(NUM_REGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dec_valid,
    input logic [RW-1:0]        dec_src_a,
    input logic [RW-1:0]        dec_dst,
    input logic                 dec_stall,
    input logic [NUM_UNITS-1:0] disp_sel,
    input logic [NUM_REGS-1:0]  reg_busy,
    input logic [NUM_UNITS-1:0] unit_busy,
    input logic [NUM_REGS-1:0]  clr_vec
);
    a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_sel));

    a_r6_lowest_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_sel - 1'b1) & ~unit_busy & {NUM_UNITS{|disp_sel}}) == '0);

    a_r8_stall_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |-> (disp_sel == '0));

    a_r8_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_stall && disp_sel == '0));

    a_r5_all_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&unit_busy)) |-> dec_stall);

    a_r2_source_pending_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && reg_busy[dec_src_a] && !clr_vec[dec_src_a]) |-> dec_stall);

    a_r4_dest_pending_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && reg_busy[dec_dst] && !clr_vec[dec_dst]) |-> dec_stall);

    a_r7_busy_after_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (|disp_sel) |=> reg_busy[$past(dec_dst)]);
endmodule

bind issue_interlock issue_interlock_chk #(
    .NUM_REGS (NUM_REGS),
    .NUM_UNITS(NUM_UNITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_valid(dec_valid),
    .dec_src_a(dec_src_a),
    .dec_dst  (dec_dst),
    .dec_stall(dec_stall),
    .disp_sel (disp_sel),
    .reg_busy (reg_busy),
    .unit_busy(unit_busy),
    .clr_vec  (clr_vec)
);

// File: tb/tb_issue_interlock.sv
module tb_issue_interlock;
    localparam int NREG = 4;
    localparam int NU   = 3;
    localparam int EX   = 3;
    localparam int WB   = 2;
    localparam int RW   = $clog2(NREG);
    localparam int LAT  = EX + WB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0;
    logic [RW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic          dec_stall;
    logic [NU-1:0] disp_sel;
    logic [NREG-1:0] reg_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int rem [NU];
    int mdst [NU];

    always #4 clk = ~clk;

    issue_interlock #(
        .NUM_REGS(NREG), .NUM_UNITS(NU), .EXEC_CYCLES(EX), .WB_CYCLES(WB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
        .dec_stall(dec_stall), .disp_sel(disp_sel), .reg_busy(reg_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input bit v, input int a, input int b, input int d, output bit fired);
        bit hs, hd, fin, es;
        int gu;
        logic [NU-1:0] esel;
        logic [NREG-1:0] ebusy;
        string tag;
        @(negedge clk);
        dec_valid = v;
        dec_src_a = RW'(a);
        dec_src_b = RW'(b);
        dec_dst   = RW'(d);
        #1;
        hs = 0; hd = 0; fin = 0; gu = -1; ebusy = '0;
        for (int u = 0; u < NU; u++) begin
            if (rem[u] > 0) ebusy[mdst[u]] = 1'b1;
            if (rem[u] > 1 && (mdst[u] == a || mdst[u] == b)) hs = 1;
            if (rem[u] > 1 && mdst[u] == d) hd = 1;
            if (rem[u] == 1 && (mdst[u] == a || mdst[u] == b || mdst[u] == d)) fin = 1;
            if (rem[u] == 0 && gu < 0) gu = u;
        end
        es = v && (hs || hd || gu < 0);
        esel = '0;
        if (v && !es) esel[gu] = 1'b1;
        if (!v)             tag = "R8 invalid";
        else if (hs)        tag = "R2 source hazard";
        else if (hd)        tag = "R4 dest hazard";
        else if (gu < 0)    tag = "R5 units full";
        else if (fin)       tag = "R3 final writeback";
        else                tag = "R8 free issue";
        chk(dec_stall === es, {tag, " stall"}, int'(dec_stall), int'(es));
        chk(disp_sel === esel, "R6 unit select", int'(disp_sel), int'(esel));
        chk(reg_busy === ebusy, "R7 pending bits", int'(reg_busy), int'(ebusy));
        fired = v && !es;
        @(posedge clk);
        for (int u = 0; u < NU; u++) if (rem[u] > 0) rem[u]--;
        if (fired) begin
            rem[gu]  = LAT;
            mdst[gu] = d;
        end
    endtask

    task automatic hold_until_fire(input int a, input int b, input int d, output int n);
        bit f;
        n = 0;
        do begin
            tick(1, a, b, d, f);
            n++;
        end while (!f && n < 50);
    endtask

    task automatic drain();
        bit f;
        for (int i = 0; i < LAT + 1; i++) tick(0, 0, 0, 0, f);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit f;
        int n;
        logic [15:0] lfsr;
        bit pend;
        int pa, pb, pd;
        bit pv;
        for (int u = 0; u < NU; u++) begin rem[u] = 0; mdst[u] = 0; end
        repeat (3) @(posedge clk);
        #1;
        chk(reg_busy === '0, "R1 busy in reset", int'(reg_busy), 0);
        chk(dec_stall === 1'b0, "R1 stall in reset", int'(dec_stall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(reg_busy === '0 && disp_sel === '0, "R1 after reset", int'(reg_busy), 0);

        // R2 and R3: read-after-write spacing
        tick(1, 0, 0, 1, f);
        hold_until_fire(1, 2, 3, n);
        chk(n == LAT, "R3 dependent dispatch spacing", n, LAT);
        drain();
        tick(1, 0, 0, 2, f);
        hold_until_fire(3, 2, 0, n);
        chk(n == LAT, "R2 second-source spacing", n, LAT);
        drain();

        // R4: write-after-write
        tick(1, 0, 0, 2, f);
        hold_until_fire(0, 0, 2, n);
        chk(n == LAT, "R4 dest pending spacing", n, LAT);
        drain();

        // R5 and R6: structural stall
        tick(1, 3, 3, 0, f);
        tick(1, 3, 3, 1, f);
        tick(1, 3, 3, 2, f);
        hold_until_fire(3, 3, 3, n);
        chk(n == LAT - NU + 2, "R5 structural wait", n, LAT - NU + 2);
        drain();

        // exhaustive sweep against one producer of register 1
        for (int a = 0; a < NREG; a++)
            for (int b = 0; b < NREG; b++)
                for (int d = 0; d < NREG; d++) begin
                    int exp_n;
                    drain();
                    tick(1, 0, 0, 1, f);
                    hold_until_fire(a, b, d, n);
                    exp_n = (a == 1 || b == 1 || d == 1) ? LAT : 1;
                    chk(n == exp_n, "R2 R4 sweep spacing", n, exp_n);
                end
        drain();

        // pseudo-random traffic, instruction held while stalled
        lfsr = 16'hACE1;
        pend = 0; pa = 0; pb = 0; pd = 0; pv = 0;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (!pend) begin
                pv = (lfsr[2:0] != 3'd0);
                pa = int'(lfsr[4:3]);
                pb = int'(lfsr[7:6]);
                pd = int'(lfsr[10:9]);
            end
            tick(pv, pa, pb, pd, f);
            pend = pv && !f;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule